// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors work side by side. The first is a bimodal table of 2-bit saturating counters, selected by low address bits. The second is a gshare table of the same kind, selected by the address XORed with a global history of recent outcomes. A third table of 2-bit chooser counters, also selected by address bits, decides for each branch which component's guess becomes the final answer.

The fetch side presents a program counter on the predict port. In the same cycle it receives the final direction and both component directions. When the branch resolves, the pipeline returns the address, the real outcome and the two component directions it captured at predict time. Both component tables train on every update. The chooser trains only when the two components disagreed, and it moves toward the one that was right. The global history then shifts the outcome in. Tables reset to weakly not-taken, and the chooser resets to weakly favouring bimodal.

Top module: `tourn_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 01. Every address then predicts not-taken on all three prediction outputs, and the chooser selects the bimodal component.
- R2: The bimodal and chooser tables are indexed by pc[BIM_IDX_W+1:2] and pc[CH_IDX_W+1:2] and carry no tags. Two addresses equal in those bits share one counter.
- R3: The gshare table is indexed by pc[GSH_IDX_W+1:2] XOR the global history register, which is GSH_IDX_W bits wide.
- R4: A component counter steps up by one on a taken outcome and down by one on a not-taken outcome. It saturates at 11 and 00. Its prediction is its most significant bit (1 = taken).
- R5: The final prediction equals the gshare prediction when the chooser counter's MSB is 1, and equals the bimodal prediction when it is 0.
- R6: On an update whose reported bimodal and gshare predictions differ, the chooser counter steps up (toward gshare) if gshare matched the outcome, and steps down otherwise, saturating at both ends. When the two agree, the chooser is left unchanged.
- R7: Each accepted update shifts the outcome into bit 0 of the global history, and the older bits move up one place. Without an update the history holds.
- R8: Both component tables train on every accepted update. The gshare entry trained is the one indexed with the history value before that update's shift.
- R9: Predictions are combinational reads of table state. An update takes effect at the clock edge that accepts it and is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final chosen direction |
| pred_bim | output | 1 | Bimodal component direction |
| pred_gsh | output | 1 | Gshare component direction |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_bim_pred | input | 1 | Bimodal direction captured at predict time |
| upd_gsh_pred | input | 1 | Gshare direction captured at predict time |

## Verification
On every cycle the assertions check four things. The history shifts with each update and holds without one. A write to a component counter or chooser counter moves at most one step, in the direction the outcome asks for, and saturates at the ends. The final direction matches both components whenever they agree. The bench's scenarios cover what needs a history of updates: the reset contents, aliasing of two addresses onto one untagged entry, the chooser handing a branch over to gshare on an alternating pattern, and a long pseudo-random stream compared against an independent model of all three tables and the history.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_MIN     = 2'b00;
  localparam ctr2_t CTR_MAX     = 2'b11;
  localparam ctr2_t CTR_WEAK_NT = 2'b01;

  // saturating one-step move of a 2-bit counter
  function automatic ctr2_t sat_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? c : ctr2_t'(c + 2'd1);
    else    r = (c == CTR_MIN) ? c : ctr2_t'(c - 2'd1);
    return r;
  endfunction

  // direction carried by a counter
  function automatic logic ctr_dir(input ctr2_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tourn_ctr_table.sv
module tourn_ctr_table
  import tourn_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter ctr2_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output ctr2_t            wr_old,
  output ctr2_t            wr_new
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t entry [DEPTH];

  assign rd_ctr = entry[rd_idx];
  assign wr_old = entry[wr_idx];
  assign wr_new = sat_step(wr_old, wr_up);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= RST_VAL;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        entry[g] <= wr_new;
    end
  end
endmodule

// File: rtl/tourn_ghist.sv
module tourn_ghist #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end
endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor
  import tourn_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int BIM_IDX_W = 6,
  parameter int GSH_IDX_W = 6,
  parameter int CH_IDX_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_bim,
  output logic            pred_gsh,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_bim_pred,
  input  logic            upd_gsh_pred
);
  localparam int PC_LSB = 2;

  logic [GSH_IDX_W-1:0] ghist;
  logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
  logic [GSH_IDX_W-1:0] gsh_rd_idx, gsh_wr_idx;
  logic [CH_IDX_W-1:0]  ch_rd_idx, ch_wr_idx;
  ctr2_t bim_rd, gsh_rd, ch_rd;
  ctr2_t bim_old, bim_new, gsh_old, gsh_new, ch_old, ch_new;
  logic  bim_we, gsh_we, ch_we, ch_up, comp_disagree;

  // index generation
  assign bim_rd_idx = pred_pc[PC_LSB +: BIM_IDX_W];
  assign ch_rd_idx  = pred_pc[PC_LSB +: CH_IDX_W];
  assign gsh_rd_idx = pred_pc[PC_LSB +: GSH_IDX_W] ^ ghist;
  assign bim_wr_idx = upd_pc[PC_LSB +: BIM_IDX_W];
  assign ch_wr_idx  = upd_pc[PC_LSB +: CH_IDX_W];
  assign gsh_wr_idx = upd_pc[PC_LSB +: GSH_IDX_W] ^ ghist;

  // training events
  assign comp_disagree = upd_bim_pred ^ upd_gsh_pred;
  assign bim_we = upd_valid;
  assign gsh_we = upd_valid;
  assign ch_we  = upd_valid && comp_disagree;
  assign ch_up  = (upd_gsh_pred == upd_taken);

  tourn_ctr_table #(.IDX_W(BIM_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_bim (
    .clk(clk), .rst_n(rst_n), .rd_idx(bim_rd_idx), .rd_ctr(bim_rd),
    .wr_en(bim_we), .wr_idx(bim_wr_idx), .wr_up(upd_taken),
    .wr_old(bim_old), .wr_new(bim_new));

  tourn_ctr_table #(.IDX_W(GSH_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_gsh (
    .clk(clk), .rst_n(rst_n), .rd_idx(gsh_rd_idx), .rd_ctr(gsh_rd),
    .wr_en(gsh_we), .wr_idx(gsh_wr_idx), .wr_up(upd_taken),
    .wr_old(gsh_old), .wr_new(gsh_new));

  tourn_ctr_table #(.IDX_W(CH_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_ch (
    .clk(clk), .rst_n(rst_n), .rd_idx(ch_rd_idx), .rd_ctr(ch_rd),
    .wr_en(ch_we), .wr_idx(ch_wr_idx), .wr_up(ch_up),
    .wr_old(ch_old), .wr_new(ch_new));

  tourn_ghist #(.W(GSH_IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .bit_in(upd_taken),
    .hist(ghist));

  assign pred_bim   = ctr_dir(bim_rd);
  assign pred_gsh   = ctr_dir(gsh_rd);
  assign pred_taken = ctr_dir(ch_rd) ? pred_gsh : pred_bim;
endmodule

// File: rtl/tourn_predictor_chk.sv
module tourn_predictor_chk
  import tourn_pkg::*;
#(
  parameter int GH_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic            upd_gsh_pred,
  input logic            pred_taken,
  input logic            pred_bim,
  input logic            pred_gsh,
  input logic [GH_W-1:0] ghist,
  input logic            bim_we,
  input ctr2_t           bim_old,
  input ctr2_t           bim_new,
  input logic            gsh_we,
  input ctr2_t           gsh_old,
  input ctr2_t           gsh_new,
  input logic            ch_we,
  input ctr2_t           ch_old,
  input ctr2_t           ch_new
);
  // R7
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GH_W-2:0]), $past(upd_taken)});

  // R7
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  // R5
  agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_bim == pred_gsh) |-> (pred_taken == pred_bim));

  // R4
  bim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bim_we |-> (upd_taken ? ((bim_new == bim_old + 2'd1) || (bim_old == 2'b11 && bim_new == 2'b11))
                          : ((bim_new == bim_old - 2'd1) || (bim_old == 2'b00 && bim_new == 2'b00))));

  // R4
  gsh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gsh_we |-> (upd_taken ? ((gsh_new == gsh_old + 2'd1) || (gsh_old == 2'b11 && gsh_new == 2'b11))
                          : ((gsh_new == gsh_old - 2'd1) || (gsh_old == 2'b00 && gsh_new == 2'b00))));

  // R6
  ch_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_we |-> ((upd_gsh_pred == upd_taken) ? (ch_new >= ch_old) : (ch_new <= ch_old)));
endmodule

bind tourn_predictor tourn_predictor_chk #(.GH_W(GSH_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_gsh_pred(upd_gsh_pred), .pred_taken(pred_taken), .pred_bim(pred_bim),
  .pred_gsh(pred_gsh), .ghist(ghist), .bim_we(bim_we), .bim_old(bim_old),
  .bim_new(bim_new), .gsh_we(gsh_we), .gsh_old(gsh_old), .gsh_new(gsh_new),
  .ch_we(ch_we), .ch_old(ch_old), .ch_new(ch_new));

// File: tb/tb_tourn_predictor.sv
module tb_tourn_predictor;
  localparam int PW = 32;
  localparam int IW = 6;
  localparam int N  = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] pred_pc = '0, upd_pc = '0;
  logic pred_taken, pred_bim, pred_gsh;
  logic upd_valid = 0, upd_taken = 0, upd_bim_pred = 0, upd_gsh_pred = 0;

  int checks = 0, errors = 0;

  logic [1:0] mb [N];
  logic [1:0] mg [N];
  logic [1:0] mc [N];
  logic [IW-1:0] mh;

  always #5 clk = ~clk;

  tourn_predictor dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_bim(pred_bim), .pred_gsh(pred_gsh), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_bim_pred(upd_bim_pred),
    .upd_gsh_pred(upd_gsh_pred));

  function automatic logic [1:0] bump(input logic [1:0] c, input logic up);
    if (up)  return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [PW-1:0] pc);
    @(negedge clk);
    pred_pc = pc;
    #1;
  endtask

  // one predict then update, checked against the bench model
  task automatic branch(input logic [PW-1:0] pc, input logic t, input string tag);
    logic [IW-1:0] bi, gi;
    logic eb, eg, ef;
    peek(pc);
    bi = pc[IW+1:2];
    gi = pc[IW+1:2] ^ mh;
    eb = mb[bi][1];
    eg = mg[gi][1];
    ef = mc[bi][1] ? eg : eb;
    chk(pred_bim, eb, {tag, " R2 bimodal"});
    chk(pred_gsh, eg, {tag, " R3 gshare"});
    chk(pred_taken, ef, {tag, " R5 final"});
    upd_valid = 1; upd_pc = pc; upd_taken = t;
    upd_bim_pred = eb; upd_gsh_pred = eg;
    @(posedge clk); #1;
    upd_valid = 0;
    mb[bi] = bump(mb[bi], t);
    mg[gi] = bump(mg[gi], t);
    if (eb != eg) mc[bi] = bump(mc[bi], eg == t);
    mh = {mh[IW-2:0], t};
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      peek(32'(i * 36));
      chk(pred_bim, 1'b0, "R1 reset bimodal");
      chk(pred_gsh, 1'b0, "R1 reset gshare");
      chk(pred_taken, 1'b0, "R1 reset final");
    end
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 5; i++) branch(32'h40, 1'b1, "R4 sat-up");
    peek(32'h40);
    chk(pred_bim, 1'b1, "R4 taken after training");
    branch(32'h40, 1'b0, "R4 down1");
    peek(32'h40);
    chk(pred_bim, 1'b1, "R4 R9 11->10 still taken");
    branch(32'h40, 1'b0, "R4 down2");
    peek(32'h40);
    chk(pred_bim, 1'b0, "R4 R9 10->01 not-taken");
    for (int i = 0; i < 4; i++) branch(32'h40, 1'b0, "R4 sat-down");
    branch(32'h40, 1'b1, "R4 from floor");
    peek(32'h40);
    chk(pred_bim, 1'b0, "R4 00->01 not-taken");
  endtask

  task automatic t_alias();
    branch(32'h100, 1'b1, "R2 alias train");
    branch(32'h100, 1'b1, "R2 alias train");
    peek(32'h100 + 32'(N * 4));
    chk(pred_bim, 1'b1, "R2 aliased address shares counter");
  endtask

  task automatic t_chooser();
    for (int i = 0; i < 40; i++) branch(32'h80, i[0], "R6 alternate");
    peek(32'h80);
    chk(mc[6'h20][1], 1'b1, "R6 model chooser reached gshare");
    chk(pred_taken, pred_gsh, "R5 R6 final follows gshare");
    branch(32'h80, 1'b0, "R6 follow");
  endtask

  task automatic t_hold();
    logic b0, g0, f0;
    peek(32'h80);
    b0 = pred_bim; g0 = pred_gsh; f0 = pred_taken;
    for (int i = 0; i < 4; i++) @(posedge clk);
    peek(32'h80);
    chk(pred_gsh, g0, "R7 history holds without update");
    chk(pred_bim, b0, "R9 no update no change");
    chk(pred_taken, f0, "R9 final unchanged");
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch({22'd0, lfsr[4:0], 5'd0} | {26'd0, lfsr[9:8], 4'd0},
             lfsr[7] | lfsr[3], "R8 stream");
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mb[i] = 2'b01; mg[i] = 2'b01; mc[i] = 2'b01;
    end
    mh = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_saturate();
    t_alias();
    t_chooser();
    t_hold();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule